// File: doc/BRIEF.md
# Segmented 16-bit Host Port

This block is the host side of an associative-memory device. A host with a 16-bit bus reaches 64-bit internal resources (the comparand, two mask registers and a word of the memory array) one 16-bit segment at a time. The host uses three active-low strobes: chip enable (`ce_n`), write enable (`we_n`) and command select (`cmd_n`). These select one of four cycle types. Data cycles go to a persistently selected destination, or come from a persistently selected source. Command cycles go to an instruction output, or return the status word. A one-shot override command sends the next single command cycle to one of four internal registers instead.

The bus strobes are asynchronous to the internal clock, which runs at least four times faster than bus cycles. Each strobe passes through a synchroniser and is then turned into fall and rise events. A cycle-type state machine has five states: `ST_IDLE`, `ST_CMD_WR`, `ST_DAT_WR`, `ST_CMD_RD` and `ST_DAT_RD`. On a chip-enable fall it leaves `ST_IDLE` for the state that matches the latched `{cmd_n, we_n}`. On the chip-enable rise it returns to `ST_IDLE`. Writes take effect on the fall event. The source and destination segment counters advance on the rise event. When the last segment of a comparand or mask is written, the block pulses `cmp_start` to start an automatic compare. When the last segment of a memory word is written, the block issues a 64-bit memory write.

Top module: `seg_host_port`

## Requirements
- R1: The latched `{cmd_n, we_n}` selects the cycle type: 00 is command write, 10 is data write, 01 is command read and 11 is data read.
- R2: `dq_oe` is low whenever `ce_n` is high. It is high while `ce_n` is low only in a read cycle.
- R3: After reset, data writes and data reads use the comparand. A command read returns `status_in` unless an override is pending.
- R4: A command word with bits[15:12]=1 selects the data source, and bits[15:12]=2 selects the data destination. Bits[1:0] name the resource: 0 comparand, 1 mask 1, 2 mask 2, 3 memory. The selection holds until the next such command, and the matching segment counter restarts at 0.
- R5: Segment k is bits [16k+15:16k]. Each data write or data read advances its counter by one when the cycle ends, and the counter wraps from 3 to 0.
- R6: A data write of segment 3 to the comparand, mask 1 or mask 2 pulses `cmp_start` for one clock. A write to memory never does.
- R7: A data write of segment 3 to memory pulses `mem_wr_en` for one clock. The pulse carries the four assembled segments on `mem_wr_data` and the address register on `mem_addr`.
- R8: A command word with bits[15:12]=3 arms an override for bits[1:0]: 0 control, 1 segment control, 2 address, 3 next-free. Only the next command read or write uses it, and the default applies after that.
- R9: A command write redirected to the control register updates `ctrl_word` and pulses `cmp_start`.
- R10: The segment-control register holds the destination count in bits[1:0] and the source count in bits[3:2]. Reads return it and writes load both counters.
- R11: The next-free register is read-only. An override write to it changes no register and emits no instruction, and reads of it return `nfree_in`.
- R12: Any other command word, when no override is pending, pulses `instr_valid` for one clock with the word on `instr_word`.
- R13: Reset clears the comparand, both masks, control, address and both counters, and leaves all pulse outputs and `dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| cmd_n | input | 1 | Bus command select, low for command |
| dq_in | input | 16 | Bus write data |
| dq_out | output | 16 | Bus read data |
| dq_oe | output | 1 | Bus output enable (high drives the bus) |
| status_in | input | 16 | Status word for default command reads |
| nfree_in | input | 16 | Next-free address from the array |
| mem_rd_data | input | 64 | Memory word at the current address |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 64 | Assembled memory write word |
| mem_addr | output | 16 | Address register |
| cmp_start | output | 1 | Automatic compare request |
| comparand | output | 64 | Comparand register |
| mask1 | output | 64 | Mask register 1 |
| mask2 | output | 64 | Mask register 2 |
| ctrl_word | output | 16 | Control register |
| instr_valid | output | 1 | Instruction strobe |
| instr_word | output | 16 | Instruction word |

## Verification
Every bus strobe reaches the state machine three clock edges after it changes: two synchroniser stages, then the register that acts on the event. So register writes, pulses and counter steps appear on the third edge after the chip-enable edge. `dq_oe` falls as soon as `ce_n` rises, because it is gated by the raw strobe. The bench holds each strobe phase for six clocks and samples read data at the end of the low phase, at a falling clock edge. It reads registers and pulse counts only after the high phase has completed. Pulses are counted by a monitor on every clock, so each automatic compare and memory write is counted exactly once.

// File: rtl/shp_pkg.sv
package shp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_WR,
        ST_DAT_WR,
        ST_CMD_RD,
        ST_DAT_RD
    } hp_state_e;

    typedef enum logic [1:0] {
        RES_CMP  = 2'd0,
        RES_MSK1 = 2'd1,
        RES_MSK2 = 2'd2,
        RES_MEM  = 2'd3
    } hp_res_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SEGC  = 2'd1,
        REG_ADDR  = 2'd2,
        REG_NFREE = 2'd3
    } hp_reg_e;

    typedef enum logic [1:0] {
        OP_INSTR,
        OP_SRC,
        OP_DST,
        OP_OVR
    } hp_op_e;

    localparam logic [3:0] CODE_SRC = 4'h1;
    localparam logic [3:0] CODE_DST = 4'h2;
    localparam logic [3:0] CODE_OVR = 4'h3;

endpackage

// File: rtl/shp_edge_sync.sv
module shp_edge_sync #(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_raw,
    input  logic [W-1:0] data_raw,
    output logic [W-1:0] data_s,
    output logic         ce_fall,
    output logic         ce_rise
);

    logic [STAGES-1:0] ce_pipe;
    logic              ce_prev;
    logic [W-1:0]      d_pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_pipe <= '1;
            ce_prev <= 1'b1;
            for (int i = 0; i < STAGES; i++) d_pipe[i] <= '0;
        end else begin
            ce_pipe <= {ce_pipe[STAGES-2:0], ce_raw};
            ce_prev <= ce_pipe[STAGES-1];
            d_pipe[0] <= data_raw;
            for (int i = 1; i < STAGES; i++) d_pipe[i] <= d_pipe[i-1];
        end
    end

    assign data_s  = d_pipe[STAGES-1];
    assign ce_fall = ce_prev & ~ce_pipe[STAGES-1];
    assign ce_rise = ~ce_prev & ce_pipe[STAGES-1];

endmodule

// File: rtl/shp_seg_counter.sv
module shp_seg_counter #(
    parameter int N_SEG = 4,
    localparam int CNT_W = $clog2(N_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SEG - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (adv) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/shp_cmd_decode.sv
module shp_cmd_decode
    import shp_pkg::*;
(
    input  logic [3:0] opc,
    input  logic [1:0] sel,
    output hp_op_e     op,
    output hp_res_e    res,
    output hp_reg_e    reg_sel
);

    always_comb begin
        unique case (opc)
            CODE_SRC: op = OP_SRC;
            CODE_DST: op = OP_DST;
            CODE_OVR: op = OP_OVR;
            default:  op = OP_INSTR;
        endcase
        res     = hp_res_e'(sel);
        reg_sel = hp_reg_e'(sel);
    end

endmodule

// File: rtl/seg_host_port.sv
module seg_host_port
    import shp_pkg::*;
#(
    parameter int SEG_W       = 16,
    parameter int N_SEG       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = SEG_W * N_SEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              cmd_n,
    input  logic [SEG_W-1:0]  dq_in,
    output logic [SEG_W-1:0]  dq_out,
    output logic              dq_oe,
    input  logic [SEG_W-1:0]  status_in,
    input  logic [SEG_W-1:0]  nfree_in,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [SEG_W-1:0]  mem_addr,
    output logic              cmp_start,
    output logic [DATA_W-1:0] comparand,
    output logic [DATA_W-1:0] mask1,
    output logic [DATA_W-1:0] mask2,
    output logic [SEG_W-1:0]  ctrl_word,
    output logic              instr_valid,
    output logic [SEG_W-1:0]  instr_word
);

    localparam int CNT_W  = $clog2(N_SEG);
    localparam int SYNC_W = SEG_W + 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SEG - 1);

    // synchronised bus
    logic [SYNC_W-1:0] bus_s;
    logic              ce_fall, ce_rise;
    logic              s_we_n, s_cmd_n;
    logic [SEG_W-1:0]  s_dq;

    shp_edge_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_raw   (ce_n),
        .data_raw ({dq_in, cmd_n, we_n}),
        .data_s   (bus_s),
        .ce_fall  (ce_fall),
        .ce_rise  (ce_rise)
    );

    assign s_we_n  = bus_s[0];
    assign s_cmd_n = bus_s[1];
    assign s_dq    = bus_s[SYNC_W-1:2];

    // command decode
    hp_op_e  dec_op;
    hp_res_e dec_res;
    hp_reg_e dec_reg;

    shp_cmd_decode u_dec (
        .opc     (s_dq[SEG_W-1 -: 4]),
        .sel     (s_dq[1:0]),
        .op      (dec_op),
        .res     (dec_res),
        .reg_sel (dec_reg)
    );

    // state
    hp_state_e state_q, state_d;
    hp_res_e   src_sel_q, dst_sel_q;
    logic      ovr_pend_q;
    hp_reg_e   ovr_reg_q;
    logic      cyc_ovr_q;
    hp_reg_e   cyc_reg_q;
    logic [DATA_W-1:0] mem_stage_q;

    logic [CNT_W-1:0] src_cnt, dst_cnt;
    logic entering;
    logic plain_cmd_wr;
    logic src_clr, dst_clr, seg_load, src_adv, dst_adv;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ce_fall) begin
                    unique case ({s_cmd_n, s_we_n})
                        2'b00: state_d = ST_CMD_WR;
                        2'b10: state_d = ST_DAT_WR;
                        2'b01: state_d = ST_CMD_RD;
                        2'b11: state_d = ST_DAT_RD;
                    endcase
                end
            end
            ST_CMD_WR, ST_DAT_WR, ST_CMD_RD, ST_DAT_RD: begin
                if (ce_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter controls
    assign entering     = (state_q == ST_IDLE) && ce_fall;
    assign plain_cmd_wr = entering && (state_d == ST_CMD_WR) && !ovr_pend_q;
    assign src_clr      = plain_cmd_wr && (dec_op == OP_SRC);
    assign dst_clr      = plain_cmd_wr && (dec_op == OP_DST);
    assign seg_load     = entering && (state_d == ST_CMD_WR) && ovr_pend_q
                          && (ovr_reg_q == REG_SEGC);
    assign src_adv      = ce_rise && (state_q == ST_DAT_RD);
    assign dst_adv      = ce_rise && (state_q == ST_DAT_WR);

    shp_seg_counter #(.N_SEG(N_SEG)) u_src_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (src_clr),
        .load     (seg_load),
        .load_val (s_dq[2*CNT_W-1:CNT_W]),
        .adv      (src_adv),
        .cnt      (src_cnt)
    );

    shp_seg_counter #(.N_SEG(N_SEG)) u_dst_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (dst_clr),
        .load     (seg_load),
        .load_val (s_dq[CNT_W-1:0]),
        .adv      (dst_adv),
        .cnt      (dst_cnt)
    );

    function automatic logic [DATA_W-1:0] seg_put(
        input logic [DATA_W-1:0] old,
        input logic [CNT_W-1:0]  idx,
        input logic [SEG_W-1:0]  val
    );
        logic [DATA_W-1:0] r;
        r = old;
        r[int'(idx)*SEG_W +: SEG_W] = val;
        return r;
    endfunction

    logic dst_last;
    assign dst_last = (dst_cnt == LAST);

    // datapath, acting on the fall event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel_q   <= RES_CMP;
            dst_sel_q   <= RES_CMP;
            ovr_pend_q  <= 1'b0;
            ovr_reg_q   <= REG_CTRL;
            cyc_ovr_q   <= 1'b0;
            cyc_reg_q   <= REG_CTRL;
            comparand   <= '0;
            mask1       <= '0;
            mask2       <= '0;
            mem_stage_q <= '0;
            mem_wr_data <= '0;
            mem_wr_en   <= 1'b0;
            mem_addr    <= '0;
            ctrl_word   <= '0;
            cmp_start   <= 1'b0;
            instr_valid <= 1'b0;
            instr_word  <= '0;
        end else begin
            cmp_start   <= 1'b0;
            mem_wr_en   <= 1'b0;
            instr_valid <= 1'b0;
            if (entering) begin
                cyc_ovr_q <= ovr_pend_q;
                cyc_reg_q <= ovr_reg_q;
                unique case (state_d)
                    ST_CMD_WR: begin
                        if (ovr_pend_q) begin
                            ovr_pend_q <= 1'b0;
                            unique case (ovr_reg_q)
                                REG_CTRL: begin
                                    ctrl_word <= s_dq;
                                    cmp_start <= 1'b1;
                                end
                                REG_ADDR:  mem_addr <= s_dq;
                                REG_SEGC:  ;
                                REG_NFREE: ;
                            endcase
                        end else begin
                            unique case (dec_op)
                                OP_SRC: src_sel_q <= dec_res;
                                OP_DST: dst_sel_q <= dec_res;
                                OP_OVR: begin
                                    ovr_pend_q <= 1'b1;
                                    ovr_reg_q  <= dec_reg;
                                end
                                OP_INSTR: begin
                                    instr_valid <= 1'b1;
                                    instr_word  <= s_dq;
                                end
                            endcase
                        end
                    end
                    ST_DAT_WR: begin
                        unique case (dst_sel_q)
                            RES_CMP: begin
                                comparand <= seg_put(comparand, dst_cnt, s_dq);
                                if (dst_last) cmp_start <= 1'b1;
                            end
                            RES_MSK1: begin
                                mask1 <= seg_put(mask1, dst_cnt, s_dq);
                                if (dst_last) cmp_start <= 1'b1;
                            end
                            RES_MSK2: begin
                                mask2 <= seg_put(mask2, dst_cnt, s_dq);
                                if (dst_last) cmp_start <= 1'b1;
                            end
                            RES_MEM: begin
                                mem_stage_q <= seg_put(mem_stage_q, dst_cnt, s_dq);
                                if (dst_last) begin
                                    mem_wr_en   <= 1'b1;
                                    mem_wr_data <= seg_put(mem_stage_q, dst_cnt, s_dq);
                                end
                            end
                        endcase
                    end
                    ST_CMD_RD: begin
                        if (ovr_pend_q) ovr_pend_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    logic [DATA_W-1:0] src_word;
    logic [SEG_W-1:0]  reg_word;

    always_comb begin
        unique case (src_sel_q)
            RES_CMP:  src_word = comparand;
            RES_MSK1: src_word = mask1;
            RES_MSK2: src_word = mask2;
            RES_MEM:  src_word = mem_rd_data;
        endcase
        unique case (cyc_reg_q)
            REG_CTRL:  reg_word = ctrl_word;
            REG_SEGC:  reg_word = SEG_W'({src_cnt, dst_cnt});
            REG_ADDR:  reg_word = mem_addr;
            REG_NFREE: reg_word = nfree_in;
        endcase
        dq_oe  = 1'b0;
        dq_out = '0;
        unique case (state_q)
            ST_CMD_RD: begin
                dq_oe  = !ce_n;
                dq_out = cyc_ovr_q ? reg_word : status_in;
            end
            ST_DAT_RD: begin
                dq_oe  = !ce_n;
                dq_out = src_word[int'(src_cnt)*SEG_W +: SEG_W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_host_port_chk.sv
module seg_host_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic dq_oe,
    input logic cmp_start,
    input logic mem_wr_en,
    input logic instr_valid
);

    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe);

    // R1
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> we_n);

    // R6
    cmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |=> !cmp_start);

    // R7
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    // R6
    mem_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !cmp_start);

    // R12
    instr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);

endmodule

bind seg_host_port seg_host_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .dq_oe       (dq_oe),
    .cmp_start   (cmp_start),
    .mem_wr_en   (mem_wr_en),
    .instr_valid (instr_valid)
);

// File: tb/seg_host_port_test.sv
`timescale 1ns/1ps
module seg_host_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, cmd_n = 1'b1;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] status_in = 16'hA5C3;
    logic [15:0] nfree_in  = 16'h0077;
    logic [63:0] mem_rd_data = 64'hDEAD_BEEF_0123_4567;
    logic        mem_wr_en;
    logic [63:0] mem_wr_data;
    logic [15:0] mem_addr;
    logic        cmp_start;
    logic [63:0] comparand, mask1, mask2;
    logic [15:0] ctrl_word;
    logic        instr_valid;
    logic [15:0] instr_word;

    always #4 clk = ~clk;

    seg_host_port uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cmd_n(cmd_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .status_in(status_in), .nfree_in(nfree_in), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .mem_addr(mem_addr),
        .cmp_start(cmp_start), .comparand(comparand), .mask1(mask1), .mask2(mask2),
        .ctrl_word(ctrl_word), .instr_valid(instr_valid), .instr_word(instr_word)
    );

    int total = 0;
    int bad = 0;
    int n_cmp = 0, n_mem = 0, n_instr = 0;
    logic [63:0] last_mem_data = '0;
    logic [15:0] last_mem_addr = '0;
    logic [15:0] last_instr = '0;
    logic        done = 1'b0;

    always @(posedge clk) begin
        if (cmp_start) n_cmp++;
        if (mem_wr_en) begin
            n_mem++;
            last_mem_data = mem_wr_data;
            last_mem_addr = mem_addr;
        end
        if (instr_valid) begin
            n_instr++;
            last_instr = instr_word;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cyc: 0 command write, 1 data write, 2 command read, 3 data read
    task automatic bus(input logic [1:0] cyc, input logic [15:0] d,
                       output logic [15:0] rd, output logic oe_low);
        @(negedge clk);
        cmd_n = cyc[0];
        we_n  = cyc[1];
        dq_in = d;
        repeat (2) @(negedge clk);
        ce_n = 1'b0;
        repeat (6) @(negedge clk);
        rd     = dq_out;
        oe_low = dq_oe;
        ce_n   = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // vector: [38:35] requirement, [34:33] cycle, [32:17] word, [16] check, [15:0] expected
    localparam int NV = 19;
    localparam logic [38:0] VECS [NV] = '{
        {4'd3,  2'd1, 16'h1111, 1'b0, 16'h0000},  // R3 default destination
        {4'd5,  2'd1, 16'h2222, 1'b0, 16'h0000},
        {4'd5,  2'd1, 16'h3333, 1'b0, 16'h0000},
        {4'd6,  2'd1, 16'h4444, 1'b0, 16'h0000},  // R6 last segment
        {4'd3,  2'd3, 16'h0000, 1'b1, 16'h1111},  // R3 default source
        {4'd5,  2'd3, 16'h0000, 1'b1, 16'h2222},
        {4'd5,  2'd3, 16'h0000, 1'b1, 16'h3333},
        {4'd5,  2'd3, 16'h0000, 1'b1, 16'h4444},
        {4'd5,  2'd3, 16'h0000, 1'b1, 16'h1111},  // R5 wrap
        {4'd1,  2'd2, 16'h0000, 1'b1, 16'hA5C3},  // R1 command read gives status
        {4'd4,  2'd0, 16'h2001, 1'b0, 16'h0000},  // R4 destination mask1
        {4'd4,  2'd1, 16'hAAAA, 1'b0, 16'h0000},
        {4'd4,  2'd1, 16'hBBBB, 1'b0, 16'h0000},
        {4'd4,  2'd0, 16'h1001, 1'b0, 16'h0000},  // R4 source mask1
        {4'd4,  2'd3, 16'h0000, 1'b1, 16'hAAAA},  // R4 counter restarted
        {4'd8,  2'd0, 16'h3001, 1'b0, 16'h0000},  // R8 override segment control
        {4'd10, 2'd2, 16'h0000, 1'b1, 16'h0006},  // R10 src=1 dst=2
        {4'd8,  2'd2, 16'h0000, 1'b1, 16'hA5C3},  // R8 override consumed
        {4'd5,  2'd3, 16'h0000, 1'b1, 16'hBBBB}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic        oe;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 comparand", comparand, 64'h0);
        check("R13 mask1", mask1, 64'h0);
        check("R13 ctrl", {48'h0, ctrl_word}, 64'h0);
        check("R13 addr", {48'h0, mem_addr}, 64'h0);
        check("R13 pulses", {61'h0, cmp_start, mem_wr_en, instr_valid}, 64'h0);
        check("R2 oe in reset", {63'h0, dq_oe}, 64'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R13 oe idle", {63'h0, dq_oe}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            bus(VECS[i][34:33], VECS[i][32:17], rd, oe);
            if (VECS[i][16]) begin
                total++;
                if (rd !== VECS[i][15:0] || oe !== 1'b1) begin
                    bad++;
                    $display("FAIL R%0d vector %0d actual=%h oe=%b expected=%h",
                             VECS[i][38:35], i, rd, oe, VECS[i][15:0]);
                end
            end
        end
        check("R5 comparand assembled", comparand, 64'h4444_3333_2222_1111);
        check("R4 mask1 partial", mask1, 64'h0000_0000_BBBB_AAAA);
        check("R6 one compare so far", 64'(n_cmp), 64'd1);

        // R2: write cycles never drive, bus released on ce rise
        bus(2'd1, 16'hCCCC, rd, oe);
        check("R2 no drive in write", {63'h0, oe}, 64'h0);
        bus(2'd3, 16'h0000, rd, oe);
        check("R2 drive in read", {63'h0, oe}, 64'h1);
        @(negedge clk);
        check("R2 released after ce rise", {63'h0, dq_oe}, 64'h0);

        // R7 memory write
        bus(2'd0, 16'h2003, rd, oe);
        bus(2'd0, 16'h3002, rd, oe);
        bus(2'd0, 16'h0042, rd, oe);
        check("R8 address override", {48'h0, mem_addr}, 64'h42);
        bus(2'd1, 16'h0101, rd, oe);
        bus(2'd1, 16'h0202, rd, oe);
        bus(2'd1, 16'h0303, rd, oe);
        check("R7 no early write", 64'(n_mem), 64'd0);
        bus(2'd1, 16'h0404, rd, oe);
        check("R7 one write", 64'(n_mem), 64'd1);
        check("R7 data", last_mem_data, 64'h0404_0303_0202_0101);
        check("R7 addr", {48'h0, last_mem_addr}, 64'h42);
        check("R6 memory no compare", 64'(n_cmp), 64'd1);

        // R9 control write
        bus(2'd0, 16'h3000, rd, oe);
        bus(2'd0, 16'h00F0, rd, oe);
        check("R9 control value", {48'h0, ctrl_word}, 64'hF0);
        check("R9 compare pulse", 64'(n_cmp), 64'd2);
        check("R9 no instruction", 64'(n_instr), 64'd0);

        // R11 next-free read-only
        bus(2'd0, 16'h3003, rd, oe);
        bus(2'd0, 16'h1234, rd, oe);
        check("R11 ctrl kept", {48'h0, ctrl_word}, 64'hF0);
        check("R11 addr kept", {48'h0, mem_addr}, 64'h42);
        check("R11 no instruction", 64'(n_instr), 64'd0);
        bus(2'd2, 16'h0000, rd, oe);
        check("R11 override consumed", {48'h0, rd}, 64'hA5C3);
        bus(2'd0, 16'h3003, rd, oe);
        bus(2'd2, 16'h0000, rd, oe);
        check("R11 read next-free", {48'h0, rd}, 64'h0077);

        // R12 instruction pass-through
        bus(2'd0, 16'h5ABC, rd, oe);
        check("R12 instr count", 64'(n_instr), 64'd1);
        check("R12 instr word", {48'h0, last_instr}, 64'h5ABC);

        // R4 memory source, R10 counter load
        bus(2'd0, 16'h1003, rd, oe);
        check("R12 select not passed", 64'(n_instr), 64'd1);
        bus(2'd3, 16'h0000, rd, oe);
        check("R4 memory seg0", {48'h0, rd}, 64'h4567);
        bus(2'd3, 16'h0000, rd, oe);
        check("R4 memory seg1", {48'h0, rd}, 64'h0123);
        bus(2'd0, 16'h3001, rd, oe);
        bus(2'd0, 16'h000E, rd, oe);
        bus(2'd3, 16'h0000, rd, oe);
        check("R10 loaded source count", {48'h0, rd}, 64'hDEAD);
        bus(2'd0, 16'h3001, rd, oe);
        bus(2'd2, 16'h0000, rd, oe);
        check("R10 R5 wrapped source", {48'h0, rd}, 64'h0002);

        // R6 mask2 terminal count
        bus(2'd0, 16'h2002, rd, oe);
        for (int k = 0; k < 4; k++) bus(2'd1, 16'(k + 16'h10), rd, oe);
        check("R6 mask2 compare", 64'(n_cmp), 64'd3);
        check("R6 mask2 value", mask2, 64'h0013_0012_0011_0010);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule